// File: doc/BRIEF.md
# Test Access Instruction Register and Data Register Selector

This block sits behind a test access port state machine. It holds the instruction register as two stages: a shift stage that is loaded and shifted while an instruction scan runs, and a hold stage whose parallel value is the instruction in force. It also holds the data registers that belong to the port itself: a one-bit bypass register and a 32-bit identification register. The identification register reports either a fixed identity word or a code supplied by the user.

The state machine provides one-cycle strobes for capture, shift and update, for both the instruction path and the data path. The block decodes the held instruction into mode signals for the boundary cells and the self-test engine. It routes the data-path strobes to the register that the instruction selects. It picks the serial bit that goes to the test data output, and it drives the output enable. The boundary chain and the self-test result chain are outside the block. Only their serial outputs enter here, and their strobes leave from here.

All state changes on the rising test-clock edge, except for the output stage. The output stage changes on the falling edge so that the next device in a chain can sample it on the following rising edge.

Top module: `tap_regsel`

## Requirements
- R1: When `trst_n` is low, the hold stage is set to the identity instruction (opcode value 2) at once. When `tlr` is high at a rising edge, the same happens at that edge. Both reset `tdo_en` low. `tlr` wins over `ir_update`.
- R2: `ir_capture` loads the value 1 into the instruction shift stage, so bit 0 is 1 and every other bit is 0. `ir_shift` moves that stage one place towards bit 0, with `tdi` entering the top bit, and the bit leaving at bit 0 is what `tdo` shows.
- R3: `cur_instr` and all mode outputs keep their previous values through instruction capture and shift. They take the shifted value only at the rising edge where `ir_update` is high.
- R4: The opcodes are: 0 boundary drive test, 1 sample/preload, 2 identity, 3 user code, 4 internal test, 5 clamp, 6 high impedance, 7 run self-test. The all-ones opcode is bypass, and every other opcode also acts as bypass.
- R5: A data capture under the identity instruction loads the word {version[3:0], part[15:0], maker[10:0], 1'b1}, with bit 0 always 1. A data shift then moves it out bit 0 first, and `tdi` enters at bit 31.
- R6: A data capture under the user code instruction loads the `user_code` input value present at that rising edge into the identification register. It then shifts out exactly as in R5.
- R7: Under bypass, clamp, high impedance or an undefined opcode, the one-bit bypass register is in the path. Capture loads it with 0, and shift delays `tdi` by one clock.
- R8: Under boundary drive test, sample/preload and internal test, `tdo` follows `bsr_so`, and the data strobes are forwarded on `bsr_capture`, `bsr_shift` and `bsr_update`. Under run self-test, `tdo` follows `bist_so`. Under any other instruction the forwarded strobes stay low.
- R9: `tdo` and `tdo_en` change only on the falling edge. `tdo_en` is high only after a falling edge at which `ir_shift` or `dr_shift` was high.
- R10: `pin_from_bsr` is high for boundary drive test and clamp. `pin_hiz` is high for high impedance, `core_from_bsr` for internal test, and `bist_run` for run self-test. At most one of these four is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tlr | input | 1 | State machine is in its reset state |
| tdi | input | 1 | Serial test data in |
| ir_capture | input | 1 | Instruction capture strobe |
| ir_shift | input | 1 | Instruction shift strobe |
| ir_update | input | 1 | Instruction update strobe |
| dr_capture | input | 1 | Data capture strobe |
| dr_shift | input | 1 | Data shift strobe |
| dr_update | input | 1 | Data update strobe |
| user_code | input | 32 | User-programmable identification code |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| bist_so | input | 1 | Serial output of the self-test result chain |
| cur_instr | output | IR_W | Instruction currently in force |
| pin_from_bsr | output | 1 | Boundary cells drive the output pins |
| pin_hiz | output | 1 | Output pins held in high impedance |
| core_from_bsr | output | 1 | Boundary cells drive the core inputs |
| bist_run | output | 1 | Self-test engine is started |
| bsr_capture | output | 1 | Capture strobe forwarded to the boundary chain |
| bsr_shift | output | 1 | Shift strobe forwarded to the boundary chain |
| bsr_update | output | 1 | Update strobe forwarded to the boundary chain |
| tdo | output | 1 | Serial test data out, falling-edge register |
| tdo_en | output | 1 | Output enable for tdo |

## Verification
The bench builds the block with a four-bit instruction register. This makes a full sweep of all sixteen opcodes short: each one is loaded through a real instruction scan, and a 40-bit data scan follows under it. Undefined opcodes, the all-ones code and every defined instruction are all reached this way. The identity fields use uneven values so that a swapped or shifted field shows up in the 32 bits shifted out. The user code is changed between scans to show that it is sampled at capture time.

// File: rtl/tap_regsel_pkg.sv
package tap_regsel_pkg;

  typedef enum logic [3:0] {
    TI_EXTEST,
    TI_SAMPLE,
    TI_IDCODE,
    TI_USERCODE,
    TI_INTEST,
    TI_CLAMP,
    TI_HIGHZ,
    TI_RUNBIST,
    TI_BYPASS
  } instr_e;

  typedef enum logic [1:0] {
    SRC_BYPASS,
    SRC_ID,
    SRC_BOUNDARY,
    SRC_BIST
  } dr_src_e;

  // identification word: version | part | maker | fixed one
  function automatic logic [31:0] build_id(input logic [3:0] ver,
                                           input logic [15:0] part,
                                           input logic [10:0] maker);
    return {ver, part, maker, 1'b1};
  endfunction

  // which data register sits between tdi and tdo for an instruction
  function automatic dr_src_e route_of(input instr_e ins);
    case (ins)
      TI_IDCODE, TI_USERCODE:           return SRC_ID;
      TI_SAMPLE, TI_EXTEST, TI_INTEST:  return SRC_BOUNDARY;
      TI_RUNBIST:                       return SRC_BIST;
      default:                          return SRC_BYPASS;
    endcase
  endfunction

endpackage

// File: rtl/tap_ir.sv
module tap_ir #(
  parameter int IR_W = 4
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tlr,
  input  logic            tdi,
  input  logic            capture,
  input  logic            shift,
  input  logic            update,
  output logic [IR_W-1:0] sr,
  output logic [IR_W-1:0] hold
);
  localparam logic [IR_W-1:0] CAPT_PAT  = IR_W'(1);
  localparam logic [IR_W-1:0] RESET_OP  = IR_W'(2);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr   <= CAPT_PAT;
      hold <= RESET_OP;
    end else begin
      if (capture)    sr <= CAPT_PAT;
      else if (shift) sr <= {tdi, sr[IR_W-1:1]};
      if (tlr)         hold <= RESET_OP;
      else if (update) hold <= sr;
    end
  end
endmodule

// File: rtl/tap_ir_decode.sv
module tap_ir_decode
  import tap_regsel_pkg::*;
#(
  parameter int IR_W = 4
) (
  input  logic [IR_W-1:0] op,
  output instr_e          ins,
  output dr_src_e         src
);
  always_comb begin
    ins = TI_BYPASS;
    if (op != '1) begin
      case (op)
        IR_W'(0): ins = TI_EXTEST;
        IR_W'(1): ins = TI_SAMPLE;
        IR_W'(2): ins = TI_IDCODE;
        IR_W'(3): ins = TI_USERCODE;
        IR_W'(4): ins = TI_INTEST;
        IR_W'(5): ins = TI_CLAMP;
        IR_W'(6): ins = TI_HIGHZ;
        IR_W'(7): ins = TI_RUNBIST;
        default:  ins = TI_BYPASS;
      endcase
    end
    src = route_of(ins);
  end
endmodule

// File: rtl/tap_id_reg.sv
module tap_id_reg #(
  parameter logic [31:0] ID_WORD = 32'h0000_0001
) (
  input  logic        tck,
  input  logic        trst_n,
  input  logic        tdi,
  input  logic        sel,
  input  logic        use_user,
  input  logic        capture,
  input  logic        shift,
  input  logic [31:0] user_code,
  output logic [31:0] sr
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)              sr <= ID_WORD;
    else if (sel && capture)  sr <= use_user ? user_code : ID_WORD;
    else if (sel && shift)    sr <= {tdi, sr[31:1]};
  end
endmodule

// File: rtl/tap_bypass_reg.sv
module tap_bypass_reg (
  input  logic tck,
  input  logic trst_n,
  input  logic tdi,
  input  logic sel,
  input  logic capture,
  input  logic shift,
  output logic q
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)             q <= 1'b0;
    else if (sel && capture) q <= 1'b0;
    else if (sel && shift)   q <= tdi;
  end
endmodule

// File: rtl/tap_tdo_stage.sv
module tap_tdo_stage (
  input  logic tck,
  input  logic trst_n,
  input  logic ir_shift,
  input  logic dr_shift,
  input  logic ir_bit,
  input  logic dr_bit,
  output logic tdo,
  output logic tdo_en
);
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= ir_shift ? ir_bit : dr_bit;
      tdo_en <= ir_shift | dr_shift;
    end
  end
endmodule

// File: rtl/tap_regsel.sv
module tap_regsel
  import tap_regsel_pkg::*;
#(
  parameter int          IR_W       = 4,
  parameter logic [3:0]  ID_VERSION = 4'h1,
  parameter logic [15:0] ID_PART    = 16'h0001,
  parameter logic [10:0] ID_MAKER   = 11'h001
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tlr,
  input  logic            tdi,
  input  logic            ir_capture,
  input  logic            ir_shift,
  input  logic            ir_update,
  input  logic            dr_capture,
  input  logic            dr_shift,
  input  logic            dr_update,
  input  logic [31:0]     user_code,
  input  logic            bsr_so,
  input  logic            bist_so,
  output logic [IR_W-1:0] cur_instr,
  output logic            pin_from_bsr,
  output logic            pin_hiz,
  output logic            core_from_bsr,
  output logic            bist_run,
  output logic            bsr_capture,
  output logic            bsr_shift,
  output logic            bsr_update,
  output logic            tdo,
  output logic            tdo_en
);
  localparam logic [31:0] ID_WORD = build_id(ID_VERSION, ID_PART, ID_MAKER);

  logic [IR_W-1:0] ir_sr;
  instr_e          ins;
  dr_src_e         src;
  logic [31:0]     id_sr;
  logic            byp_q;
  logic            dr_bit;

  // named events for the checker
  logic ev_id_capture;
  logic ev_byp_capture;
  logic sel_id;
  logic sel_byp;
  logic sel_bsr;

  tap_ir #(.IR_W(IR_W)) u_ir (
    .tck(tck), .trst_n(trst_n), .tlr(tlr), .tdi(tdi),
    .capture(ir_capture), .shift(ir_shift), .update(ir_update),
    .sr(ir_sr), .hold(cur_instr)
  );

  tap_ir_decode #(.IR_W(IR_W)) u_dec (
    .op(cur_instr), .ins(ins), .src(src)
  );

  assign sel_id  = (src == SRC_ID);
  assign sel_byp = (src == SRC_BYPASS);
  assign sel_bsr = (src == SRC_BOUNDARY);

  assign ev_id_capture  = dr_capture && (ins == TI_IDCODE);
  assign ev_byp_capture = dr_capture && sel_byp;

  tap_id_reg #(.ID_WORD(ID_WORD)) u_id (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .sel(sel_id),
    .use_user(ins == TI_USERCODE), .capture(dr_capture), .shift(dr_shift),
    .user_code(user_code), .sr(id_sr)
  );

  tap_bypass_reg u_byp (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .sel(sel_byp),
    .capture(dr_capture), .shift(dr_shift), .q(byp_q)
  );

  always_comb begin
    case (src)
      SRC_ID:       dr_bit = id_sr[0];
      SRC_BOUNDARY: dr_bit = bsr_so;
      SRC_BIST:     dr_bit = bist_so;
      default:      dr_bit = byp_q;
    endcase
  end

  assign bsr_capture = sel_bsr && dr_capture;
  assign bsr_shift   = sel_bsr && dr_shift;
  assign bsr_update  = sel_bsr && dr_update;

  assign pin_from_bsr  = (ins == TI_EXTEST) || (ins == TI_CLAMP);
  assign pin_hiz       = (ins == TI_HIGHZ);
  assign core_from_bsr = (ins == TI_INTEST);
  assign bist_run      = (ins == TI_RUNBIST);

  tap_tdo_stage u_tdo (
    .tck(tck), .trst_n(trst_n), .ir_shift(ir_shift), .dr_shift(dr_shift),
    .ir_bit(ir_sr[0]), .dr_bit(dr_bit), .tdo(tdo), .tdo_en(tdo_en)
  );
endmodule

// File: rtl/tap_regsel_chk.sv
module tap_regsel_chk #(
  parameter int          IR_W    = 4,
  parameter logic [31:0] ID_WORD = 32'h0000_0001
) (
  input logic            tck,
  input logic            trst_n,
  input logic            tlr,
  input logic            ir_capture,
  input logic            ir_update,
  input logic [IR_W-1:0] cur_instr,
  input logic [IR_W-1:0] ir_sr,
  input logic            ev_byp_capture,
  input logic            byp_q,
  input logic            ev_id_capture,
  input logic [31:0]     id_sr,
  input logic [3:0]      modes
);
  AST_TLR_IDCODE: assert property (@(posedge tck) disable iff (!trst_n)
    tlr |=> (cur_instr == IR_W'(2))); // R1

  AST_IR_CAPTURE_PAT: assert property (@(posedge tck) disable iff (!trst_n)
    ir_capture |=> (ir_sr[1:0] == 2'b01)); // R2

  AST_HOLD_UNTIL_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
    (!ir_update && !tlr) |=> $stable(cur_instr)); // R3

  AST_ID_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
    ev_id_capture |=> (id_sr == ID_WORD)); // R5

  AST_BYP_CAPTURE_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
    ev_byp_capture |=> !byp_q); // R7

  AST_MODES_EXCLUSIVE: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0(modes)); // R10
endmodule

bind tap_regsel tap_regsel_chk #(.IR_W(IR_W), .ID_WORD(ID_WORD)) u_chk (
  .tck(tck), .trst_n(trst_n), .tlr(tlr), .ir_capture(ir_capture),
  .ir_update(ir_update), .cur_instr(cur_instr), .ir_sr(ir_sr),
  .ev_byp_capture(ev_byp_capture), .byp_q(byp_q),
  .ev_id_capture(ev_id_capture), .id_sr(id_sr),
  .modes({pin_from_bsr, pin_hiz, core_from_bsr, bist_run})
);

// File: tb/tap_regsel_tb.sv
module tap_regsel_tb;
  localparam int          IR_W = 4;
  localparam logic [3:0]  VER  = 4'hA;
  localparam logic [15:0] PART = 16'h5C3E;
  localparam logic [10:0] MAKR = 11'h2B5;
  localparam int          NB   = 40;

  logic tck = 1'b0;
  always #4 tck = ~tck;

  logic trst_n = 1'b0, tlr = 1'b0, tdi = 1'b0;
  logic ir_capture = 1'b0, ir_shift = 1'b0, ir_update = 1'b0;
  logic dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0;
  logic [31:0] user_code = 32'h1357_9BDF;
  logic bsr_so = 1'b0, bist_so = 1'b0;
  logic [IR_W-1:0] cur_instr;
  logic pin_from_bsr, pin_hiz, core_from_bsr, bist_run;
  logic bsr_capture, bsr_shift, bsr_update, tdo, tdo_en;

  tap_regsel #(.IR_W(IR_W), .ID_VERSION(VER), .ID_PART(PART), .ID_MAKER(MAKR)) u_dut (
    .tck(tck), .trst_n(trst_n), .tlr(tlr), .tdi(tdi),
    .ir_capture(ir_capture), .ir_shift(ir_shift), .ir_update(ir_update),
    .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
    .user_code(user_code), .bsr_so(bsr_so), .bist_so(bist_so),
    .cur_instr(cur_instr), .pin_from_bsr(pin_from_bsr), .pin_hiz(pin_hiz),
    .core_from_bsr(core_from_bsr), .bist_run(bist_run),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
    .tdo(tdo), .tdo_en(tdo_en)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic cyc();
    @(posedge tck); #1;
  endtask

  // 0 bypass, 1 identity, 2 user code, 3 boundary, 4 self-test
  function automatic int cls_of(input int op);
    case (op)
      2: return 1;
      3: return 2;
      0, 1, 4: return 3;
      7: return 4;
      default: return 0;
    endcase
  endfunction

  // {pin_from_bsr, pin_hiz, core_from_bsr, bist_run}
  function automatic logic [3:0] modes_of(input int op);
    case (op)
      0, 5: return 4'b1000;
      6:    return 4'b0100;
      4:    return 4'b0010;
      7:    return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [NB-1:0] exp_dr(input int op, input logic [63:0] pat,
      input logic [63:0] pb, input logic [63:0] pr, input logic [31:0] uc);
    logic [NB-1:0] e;
    logic [31:0] w;
    w = (32'(VER) << 28) | (32'(PART) << 12) | (32'(MAKR) << 1) | 32'd1;
    if (cls_of(op) == 2) w = uc;
    for (int i = 0; i < NB; i++) begin
      case (cls_of(op))
        1, 2: e[i] = (i < 32) ? w[i] : pat[i-32];
        3:    e[i] = pb[i];
        4:    e[i] = pr[i];
        default: e[i] = (i == 0) ? 1'b0 : pat[i-1];
      endcase
    end
    return e;
  endfunction

  logic [3:0] cur_modes;
  assign cur_modes = {pin_from_bsr, pin_hiz, core_from_bsr, bist_run};

  task automatic ir_scan(input logic [IR_W-1:0] op);
    logic [IR_W-1:0] prev_i, outb;
    logic [3:0] prev_m;
    logic held, en_ok;
    prev_i = cur_instr; prev_m = cur_modes; held = 1'b1; en_ok = 1'b1;
    ir_capture = 1'b1; cyc(); ir_capture = 1'b0;
    if (cur_instr !== prev_i) held = 1'b0;
    ir_shift = 1'b1;
    for (int i = 0; i < IR_W; i++) begin
      tdi = op[i];
      @(negedge tck); #1;
      outb[i] = tdo;
      if (!tdo_en) en_ok = 1'b0;
      @(posedge tck); #1;
      if (cur_instr !== prev_i || cur_modes !== prev_m) held = 1'b0;
    end
    ir_shift = 1'b0;
    chk("R2 ir capture pattern out", 64'(outb), 64'(IR_W'(1)));
    chk("R3 old instruction held in shift", 64'(held), 64'd1);
    chk("R9 tdo_en during ir shift", 64'(en_ok), 64'd1);
    ir_update = 1'b1; cyc(); ir_update = 1'b0;
    chk("R3 instruction at update", 64'(cur_instr), 64'(op));
  endtask

  task automatic dr_scan(input logic [63:0] pat, input logic [63:0] pb, input logic [63:0] pr,
      output logic [NB-1:0] o, output logic en_ok, output logic stab_ok,
      output logic [2:0] fwd);
    en_ok = 1'b1; stab_ok = 1'b1;
    dr_capture = 1'b1; #1 fwd[2] = bsr_capture;
    cyc(); dr_capture = 1'b0; dr_shift = 1'b1;
    for (int i = 0; i < NB; i++) begin
      tdi = pat[i]; bsr_so = pb[i]; bist_so = pr[i];
      @(negedge tck); #1;
      o[i] = tdo;
      if (!tdo_en) en_ok = 1'b0;
      if (i == 0) fwd[1] = bsr_shift;
      @(posedge tck); #1;
      if (tdo !== o[i]) stab_ok = 1'b0;
    end
    dr_shift = 1'b0; dr_update = 1'b1; #1 fwd[0] = bsr_update;
    @(negedge tck); #1;
    if (tdo_en) en_ok = 1'b0;
    @(posedge tck); #1; dr_update = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [NB-1:0] o;
    logic en_ok, stab_ok;
    logic [2:0] fwd;
    logic [63:0] pat, pb, pr;
    repeat (3) @(posedge tck);
    #1;
    chk("R1 reset instruction", 64'(cur_instr), 64'd2);
    chk("R1 reset tdo_en", 64'(tdo_en), 64'd0);
    trst_n = 1'b1;
    cyc();

    for (int op = 0; op < 16; op++) begin
      ir_scan(IR_W'(op));
      chk("R4 R10 decoded modes", 64'(cur_modes), 64'(modes_of(op)));
      pat = 64'hC3A5_96F0_1E2D_4B78 ^ (64'(op) * 64'h9E37_79B9_7F4A_7C15);
      pb  = {pat[31:0], pat[63:32]} ^ 64'h0F0F_3C3C_5A5A_6969;
      pr  = ~pat;
      dr_scan(pat, pb, pr, o, en_ok, stab_ok, fwd);
      case (cls_of(op))
        1: chk("R5 identity word out", 64'(o), 64'(exp_dr(op, pat, pb, pr, user_code)));
        2: chk("R6 user code out", 64'(o), 64'(exp_dr(op, pat, pb, pr, user_code)));
        3: chk("R8 boundary chain out", 64'(o), 64'(exp_dr(op, pat, pb, pr, user_code)));
        4: chk("R8 self-test chain out", 64'(o), 64'(exp_dr(op, pat, pb, pr, user_code)));
        default: chk("R7 bypass delay", 64'(o), 64'(exp_dr(op, pat, pb, pr, user_code)));
      endcase
      chk("R8 forwarded strobes", 64'(fwd), (cls_of(op) == 3) ? 64'd7 : 64'd0);
      chk("R9 tdo_en only in shift", 64'(en_ok), 64'd1);
      chk("R9 tdo stable at rising edge", 64'(stab_ok), 64'd1);
    end

    // R6: user code sampled at the capture edge
    user_code = 32'hFEDC_0246;
    ir_scan(IR_W'(3));
    pat = 64'h0123_4567_89AB_CDEF;
    dr_scan(pat, 64'd0, 64'd0, o, en_ok, stab_ok, fwd);
    chk("R6 new user code out", 64'(o), 64'(exp_dr(3, pat, 64'd0, 64'd0, 32'hFEDC_0246)));

    // R1: synchronous reset strobe restores the identity instruction
    ir_scan(IR_W'(5));
    tlr = 1'b1; cyc(); tlr = 1'b0;
    chk("R1 tlr restores identity", 64'(cur_instr), 64'd2);
    chk("R1 R10 modes after tlr", 64'(cur_modes), 64'd0);

    // R1: tlr wins over a simultaneous update
    ir_scan(IR_W'(6));
    ir_capture = 1'b1; cyc(); ir_capture = 1'b0;
    ir_update = 1'b1; tlr = 1'b1; cyc(); ir_update = 1'b0; tlr = 1'b0;
    chk("R1 tlr priority over update", 64'(cur_instr), 64'd2);

    // R1: asynchronous reset mid-run
    ir_scan(IR_W'(7));
    trst_n = 1'b0; #2;
    chk("R1 async reset instruction", 64'(cur_instr), 64'd2);
    chk("R1 async reset tdo_en", 64'(tdo_en), 64'd0);
    cyc(); trst_n = 1'b1; cyc();

    finish_run();
  end
endmodule